// File: doc/BRIEF.md
# Holdover Mode Controller

This block decides the operating mode of one digitally controlled clock loop. It watches a loss flag and an off-frequency flag for each candidate input, a history-valid flag from the frequency averager, and a completion flag from the exit ramp generator. From these it moves between four modes: free-run, locked, holdover and reacquire. It also names the input the loop follows and picks which frequency word drives the oscillator.

In the locked mode the tracking word passes straight to the output. When the followed input fails and nothing else is usable, the block enters holdover. There it uses the averaged word if history was valid at entry, and a frozen copy of the last good tracking word if it was not. When any input recovers, the block enters reacquire. It pulses a start strobe to the ramp generator and routes the ramp word to the output until the ramp reports done, so the return to lock is a linear sweep and never a step.

All state changes happen on the rising clock edge. The reset is synchronous and active high.

Top module: `hold_mode_ctrl`

## Requirements
- R1: An input counts as usable only when both its loss flag and its off-frequency flag are low; a single raised flag makes it unusable.
- R2: While reset is high and on the first cycle after it, the state is free-run: mode_o = 4'b0001, sel_o = 0, holdover_o = 0, ramp_start_o = 0 and freq_word_o = 0. The block stays in free-run until an input is usable. mode_o is always one-hot: bit0 free-run, bit1 locked, bit2 holdover, bit3 reacquire.
- R3: Whenever the block picks an input, it takes the usable input with the lowest index. While the followed input stays usable, the block keeps it even if a lower-index input becomes usable.
- R4: If the followed input becomes unusable while locked and another input is usable, the block switches on the next edge to the lowest usable index and stays locked, without entering holdover.
- R5: Holdover is entered only on an edge at which no input is usable.
- R6: In the locked mode, freq_word_o equals track_word_i and src_o = 0. The frozen word takes track_word_i on every edge at which the block is locked and the followed input is usable.
- R7: On entry to holdover, the block latches hist_valid_i. If the latched value is 1, freq_word_o = avg_word_i and src_o = 1. If it is 0, freq_word_o is the frozen word and src_o = 2. A change of hist_valid_i during holdover has no effect.
- R8: In holdover, an edge with any usable input moves the block to reacquire on the lowest usable index. ramp_start_o is high for exactly the first reacquire cycle. During reacquire, freq_word_o = ramp_word_i and src_o = 3.
- R9: In reacquire, with the followed input usable, ramp_done_i high moves the block to locked on the next edge.
- R10: In reacquire, if the followed input becomes unusable, the block returns to holdover when nothing is usable. Otherwise it switches to the lowest usable index, stays in reacquire and raises ramp_start_o again for one cycle.
- R11: holdover_o is a registered flag that is high exactly in the cycles in which the mode is holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| los_i | input | N_IN | Per-input loss flag |
| oof_i | input | N_IN | Per-input off-frequency flag |
| hist_valid_i | input | 1 | Averager has valid history |
| ramp_done_i | input | 1 | Exit ramp has reached its target |
| track_word_i | input | WORD_W | Frequency word from the tracking loop |
| avg_word_i | input | WORD_W | Averaged holdover frequency word |
| ramp_word_i | input | WORD_W | Frequency word from the exit ramp |
| freq_word_o | output | WORD_W | Selected frequency word |
| src_o | output | 2 | Word source: 0 track, 1 average, 2 frozen, 3 ramp |
| mode_o | output | 4 | One-hot mode |
| sel_o | output | IDXW | Index of the followed input |
| holdover_o | output | 1 | Registered holdover flag |
| ramp_start_o | output | 1 | One-cycle strobe that starts the exit ramp |

## Verification
A wrong mode register shows at once in mode_o and src_o, and in freq_word_o, in the cycle after the edge that misbehaved. A wrong selection index shows in sel_o in that same cycle. A frozen-word register that captured at the wrong time, or a history choice latched at the wrong time, stays hidden until holdover is entered. It then shows as a wrong freq_word_o in the first holdover cycle. A missing or repeated ramp strobe shows in the first one or two reacquire cycles.

// File: rtl/hold_mode_pkg.sv
package hold_mode_pkg;

  typedef enum logic [1:0] {
    MD_FREE  = 2'd0,
    MD_LOCK  = 2'd1,
    MD_HOLD  = 2'd2,
    MD_REACQ = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SRC_TRACK  = 2'd0,
    SRC_AVG    = 2'd1,
    SRC_FROZEN = 2'd2,
    SRC_RAMP   = 2'd3
  } src_e;

  function automatic logic [3:0] mode_onehot(mode_e m);
    return 4'b0001 << m;
  endfunction

  function automatic src_e pick_src(mode_e m, logic use_avg);
    case (m)
      MD_LOCK:  return SRC_TRACK;
      MD_HOLD:  return use_avg ? SRC_AVG : SRC_FROZEN;
      MD_REACQ: return SRC_RAMP;
      default:  return SRC_FROZEN;
    endcase
  endfunction

endpackage

// File: rtl/hom_input_select.sv
module hom_input_select #(
  parameter int N_IN = 4,
  parameter int IDXW = 2
) (
  input  logic [N_IN-1:0] los_i,
  input  logic [N_IN-1:0] oof_i,
  output logic [N_IN-1:0] vmask_o,
  output logic            any_valid_o,
  output logic [IDXW-1:0] best_idx_o
);

  // R1: usable only with both flags low
  assign vmask_o     = ~(los_i | oof_i);
  assign any_valid_o = |vmask_o;

  // R3: lowest usable index wins
  always_comb begin
    best_idx_o = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (vmask_o[i]) best_idx_o = IDXW'(i);
    end
  end

endmodule

// File: rtl/hom_fsm.sv
module hom_fsm
  import hold_mode_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] vmask_i,
  input  logic            any_valid_i,
  input  logic [IDXW-1:0] best_idx_i,
  input  logic            hist_valid_i,
  input  logic            ramp_done_i,
  output mode_e           mode_o,
  output logic [IDXW-1:0] sel_o,
  output logic            hold_flag_o,
  output logic            ramp_start_o,
  output logic            use_avg_o,
  output logic            frozen_en_o
);

  mode_e           st, nxt;
  logic [IDXW-1:0] sel, nsel;
  logic            restart;
  logic            sel_ok;
  logic            hold_entry;

  assign sel_ok      = vmask_i[sel];
  assign frozen_en_o = (st == MD_LOCK) && sel_ok;
  assign hold_entry  = (nxt == MD_HOLD) && (st != MD_HOLD);

  always_comb begin
    nxt     = st;
    nsel    = sel;
    restart = 1'b0;
    case (st)
      MD_FREE: begin
        if (any_valid_i) begin
          nxt  = MD_LOCK;
          nsel = best_idx_i;
        end
      end
      MD_LOCK: begin
        if (!sel_ok) begin
          if (any_valid_i) nsel = best_idx_i;
          else             nxt  = MD_HOLD;
        end
      end
      MD_HOLD: begin
        if (any_valid_i) begin
          nxt     = MD_REACQ;
          nsel    = best_idx_i;
          restart = 1'b1;
        end
      end
      default: begin
        if (!sel_ok) begin
          if (any_valid_i) begin
            nsel    = best_idx_i;
            restart = 1'b1;
          end else begin
            nxt = MD_HOLD;
          end
        end else if (ramp_done_i) begin
          nxt = MD_LOCK;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= MD_FREE;
      sel          <= '0;
      hold_flag_o  <= 1'b0;
      ramp_start_o <= 1'b0;
      use_avg_o    <= 1'b0;
    end else begin
      st           <= nxt;
      sel          <= nsel;
      hold_flag_o  <= (nxt == MD_HOLD);
      ramp_start_o <= restart;
      if (hold_entry) use_avg_o <= hist_valid_i;
    end
  end

  assign mode_o = st;
  assign sel_o  = sel;

endmodule

// File: rtl/hom_word_mux.sv
module hom_word_mux
  import hold_mode_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode_i,
  input  logic              use_avg_i,
  input  logic              frozen_en_i,
  input  logic [WORD_W-1:0] track_word_i,
  input  logic [WORD_W-1:0] avg_word_i,
  input  logic [WORD_W-1:0] ramp_word_i,
  output logic [WORD_W-1:0] word_o,
  output src_e              src_o
);

  logic [WORD_W-1:0] frozen_q;

  always_ff @(posedge clk) begin
    if (rst)              frozen_q <= '0;
    else if (frozen_en_i) frozen_q <= track_word_i;
  end

  assign src_o = pick_src(mode_i, use_avg_i);

  always_comb begin
    case (src_o)
      SRC_TRACK: word_o = track_word_i;
      SRC_AVG:   word_o = avg_word_i;
      SRC_RAMP:  word_o = ramp_word_i;
      default:   word_o = frozen_q;
    endcase
  end

endmodule

// File: rtl/hold_mode_ctrl.sv
module hold_mode_ctrl
  import hold_mode_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int WORD_W = 32,
  localparam int IDXW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   los_i,
  input  logic [N_IN-1:0]   oof_i,
  input  logic              hist_valid_i,
  input  logic              ramp_done_i,
  input  logic [WORD_W-1:0] track_word_i,
  input  logic [WORD_W-1:0] avg_word_i,
  input  logic [WORD_W-1:0] ramp_word_i,
  output logic [WORD_W-1:0] freq_word_o,
  output logic [1:0]        src_o,
  output logic [3:0]        mode_o,
  output logic [IDXW-1:0]   sel_o,
  output logic              holdover_o,
  output logic              ramp_start_o
);

  logic [N_IN-1:0] vmask;
  logic            any_valid;
  logic [IDXW-1:0] best_idx;
  mode_e           mode;
  logic            use_avg;
  logic            frozen_en;
  src_e            src;

  hom_input_select #(.N_IN(N_IN), .IDXW(IDXW)) u_sel (
    .los_i       (los_i),
    .oof_i       (oof_i),
    .vmask_o     (vmask),
    .any_valid_o (any_valid),
    .best_idx_o  (best_idx)
  );

  hom_fsm #(.N_IN(N_IN), .IDXW(IDXW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .vmask_i      (vmask),
    .any_valid_i  (any_valid),
    .best_idx_i   (best_idx),
    .hist_valid_i (hist_valid_i),
    .ramp_done_i  (ramp_done_i),
    .mode_o       (mode),
    .sel_o        (sel_o),
    .hold_flag_o  (holdover_o),
    .ramp_start_o (ramp_start_o),
    .use_avg_o    (use_avg),
    .frozen_en_o  (frozen_en)
  );

  hom_word_mux #(.WORD_W(WORD_W)) u_mux (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode),
    .use_avg_i    (use_avg),
    .frozen_en_i  (frozen_en),
    .track_word_i (track_word_i),
    .avg_word_i   (avg_word_i),
    .ramp_word_i  (ramp_word_i),
    .word_o       (freq_word_o),
    .src_o        (src)
  );

  assign mode_o = mode_onehot(mode);
  assign src_o  = src;

endmodule

// File: rtl/hold_mode_ctrl_chk.sv
module hold_mode_ctrl_chk #(
  parameter int N_IN   = 4,
  parameter int WORD_W = 32,
  parameter int IDXW   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_IN-1:0]   los_i,
  input logic [N_IN-1:0]   oof_i,
  input logic              ramp_done_i,
  input logic [WORD_W-1:0] track_word_i,
  input logic [WORD_W-1:0] ramp_word_i,
  input logic [WORD_W-1:0] freq_word_o,
  input logic [1:0]        src_o,
  input logic [3:0]        mode_o,
  input logic [IDXW-1:0]   sel_o,
  input logic              holdover_o
);

  logic [N_IN-1:0] usable;
  assign usable = ~(los_i | oof_i);

  assert_reset_free_R2: assert property (@(posedge clk)
    rst |=> (mode_o == 4'b0001) && !holdover_o);

  assert_mode_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_o) == 1);

  assert_leave_free_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 4'b0001 && usable != '0) |=> mode_o == 4'b0010);

  assert_switch_stays_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 4'b0010 && !usable[sel_o] && usable != '0) |=> mode_o == 4'b0010);

  assert_hold_entry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(holdover_o) |-> $past(usable) == '0);

  assert_track_word_R6: assert property (@(posedge clk) disable iff (rst)
    mode_o == 4'b0010 |-> (freq_word_o == track_word_i) && (src_o == 2'd0));

  assert_hold_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 4'b0100 && usable != '0) |=> mode_o == 4'b1000);

  assert_ramp_word_R8: assert property (@(posedge clk) disable iff (rst)
    mode_o == 4'b1000 |-> (freq_word_o == ramp_word_i) && (src_o == 2'd3));

  assert_ramp_done_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 4'b1000 && usable[sel_o] && ramp_done_i) |=> mode_o == 4'b0010);

  assert_reacq_fail_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 4'b1000 && usable == '0) |=> mode_o == 4'b0100);

  assert_hold_flag_R11: assert property (@(posedge clk) disable iff (rst)
    holdover_o == (mode_o == 4'b0100));

endmodule

bind hold_mode_ctrl hold_mode_ctrl_chk #(.N_IN(N_IN), .WORD_W(WORD_W), .IDXW(IDXW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .los_i        (los_i),
  .oof_i        (oof_i),
  .ramp_done_i  (ramp_done_i),
  .track_word_i (track_word_i),
  .ramp_word_i  (ramp_word_i),
  .freq_word_o  (freq_word_o),
  .src_o        (src_o),
  .mode_o       (mode_o),
  .sel_o        (sel_o),
  .holdover_o   (holdover_o)
);

// File: tb/hold_mode_ctrl_bench.sv
module hold_mode_ctrl_bench;

  localparam int N  = 3;
  localparam int W  = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  los, oof;
  logic          hist_valid, ramp_done;
  logic [W-1:0]  track_word, avg_word, ramp_word;
  logic [W-1:0]  freq_word;
  logic [1:0]    src;
  logic [3:0]    mode;
  logic [IW-1:0] sel;
  logic          holdover, ramp_start;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hold_mode_ctrl #(.N_IN(N), .WORD_W(W)) u_hold_mode_ctrl (
    .clk (clk), .rst (rst), .los_i (los), .oof_i (oof),
    .hist_valid_i (hist_valid), .ramp_done_i (ramp_done),
    .track_word_i (track_word), .avg_word_i (avg_word), .ramp_word_i (ramp_word),
    .freq_word_o (freq_word), .src_o (src), .mode_o (mode), .sel_o (sel),
    .holdover_o (holdover), .ramp_start_o (ramp_start)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic state_is(input string tag, input logic [3:0] m, input int s,
                          input logic h, input logic rs);
    chk({tag, " mode"}, 32'(mode), 32'(m));
    chk({tag, " sel"}, 32'(sel), 32'(s));
    chk({tag, " holdover R11"}, 32'(holdover), 32'(h));
    chk({tag, " ramp_start"}, 32'(ramp_start), 32'(rs));
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; los = '1; oof = '0; hist_valid = 1'b0; ramp_done = 1'b0;
    track_word = 16'h0; avg_word = 16'h5555; ramp_word = 16'hABCD;
    step(); step();
    // R2: reset state
    state_is("R2 reset", 4'b0001, 0, 1'b0, 1'b0);
    chk("R2 reset freq", 32'(freq_word), 32'h0);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      state_is("R2 free-run with nothing usable", 4'b0001, 0, 1'b0, 1'b0);
    end

    // R1 R3: sweep all flag combinations from free-run
    for (int l = 0; l < 8; l++) begin
      for (int o = 0; o < 8; o++) begin
        logic [N-1:0] m, lb;
        int exp_idx;
        rst = 1'b1; los = l[N-1:0]; oof = o[N-1:0];
        step();
        rst = 1'b0;
        step();
        m  = ~(l[N-1:0] | o[N-1:0]);
        lb = m & (~m + 3'd1);
        exp_idx = (m == 0) ? 0 : $clog2(lb);
        chk("R1 acquire mode", 32'(mode), (m == 0) ? 32'h1 : 32'h2);
        chk("R3 acquire lowest index", 32'(sel), 32'(exp_idx));
      end
    end

    // R3 R6: lock on input 1, track word passes through
    rst = 1'b1; los = 3'b001; oof = 3'b000; track_word = 16'h1234;
    step(); rst = 1'b0; step();
    state_is("R3 lock on 1", 4'b0010, 1, 1'b0, 1'b0);
    chk("R6 track word", 32'(freq_word), 32'h1234);
    chk("R6 src track", 32'(src), 32'h0);
    los = 3'b000; step();
    state_is("R3 non-revertive", 4'b0010, 1, 1'b0, 1'b0);

    // R4: followed input goes off-frequency, switch to lowest usable
    oof = 3'b010; step();
    state_is("R4 switch without holdover", 4'b0010, 0, 1'b0, 1'b0);
    track_word = 16'h4321; step();

    // R5 R7: all fail with no history, frozen word holds last good value
    los = 3'b111; track_word = 16'h9999; step();
    state_is("R5 enter holdover", 4'b0100, 0, 1'b1, 1'b0);
    chk("R7 frozen word", 32'(freq_word), 32'h4321);
    chk("R7 src frozen", 32'(src), 32'h2);
    hist_valid = 1'b1; step();
    chk("R7 history change ignored", 32'(freq_word), 32'h4321);

    // R8: input 2 recovers
    los = 3'b011; step();
    state_is("R8 reacquire on 2", 4'b1000, 2, 1'b0, 1'b1);
    chk("R8 ramp word", 32'(freq_word), 32'hABCD);
    chk("R8 src ramp", 32'(src), 32'h3);
    step();
    chk("R8 strobe one cycle", 32'(ramp_start), 32'h0);

    // R10: fails during ramp, none usable -> holdover with average (R7)
    los = 3'b111; step();
    state_is("R10 back to holdover", 4'b0100, 2, 1'b1, 1'b0);
    chk("R7 average word", 32'(freq_word), 32'h5555);
    chk("R7 src average", 32'(src), 32'h1);

    // R8 then R10 reselect during ramp
    los = 3'b110; oof = 3'b000; step();
    state_is("R8 reacquire on 0", 4'b1000, 0, 1'b0, 1'b1);
    step();
    los = 3'b001; step();
    state_is("R10 reselect during ramp", 4'b1000, 1, 1'b0, 1'b1);

    // R9: ramp done returns to lock
    ramp_done = 1'b1; step(); ramp_done = 1'b0;
    state_is("R9 ramp done locks", 4'b0010, 1, 1'b0, 1'b0);
    chk("R9 track word after lock", 32'(freq_word), 32'h9999);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule